// File: doc/BRIEF.md
# Periodic Interval Down-Counter Timer

This block is a register-mapped down-counter that raises a periodic interrupt. Software programs a modulus and a control word through a small write/read port. On each cycle where the prescaled enable input is high, the counter decrements by one. When the counter is at zero, the next enabled cycle either reloads the modulus or wraps to all ones, so the counter also runs as a free-running counter.

When the count moves from one to zero on an enabled cycle, a sticky event flag is set. The interrupt line is high while that flag and the interrupt-enable bit are both set. Software can halt counting and then advance the counter one count at a time with a guarded single-step. It can also copy the modulus into the counter on demand, write the counter directly, let a modulus write take effect at once, and freeze counting while an external debug input is high.

The block has three addresses: address 0 for the modulus, address 1 for the live count and address 2 for control/status. Address 3 reads as zero.

Top module: `itmr_top`

## Requirements
- R1: After reset the modulus, the count, every control bit and `irq` are 0.
- R2: With the reload bit set, an enabled cycle with the count at 0 loads the modulus into the counter. This reload does not set the flag.
- R3: With the reload bit clear, an enabled cycle with the count at 0 sets the count to all ones. Otherwise each enabled running cycle lowers the count by exactly 1, and a cycle with `tick_en` low leaves it unchanged.
- R4: A write to address 0 sets the modulus, and reading address 0 returns it. Reading address 1 returns the live count, and a write to address 1 loads the counter with the written value.
- R5: With the overwrite bit (control bit 4) set, a write to address 0 also loads the counter in the same cycle. With it clear, the counter is left unchanged.
- R6: Control bit 2 is the event flag. It is set by an enabled cycle that moves the count from 1 to 0, and it stays set until a control write with bit 2 = 1 clears it. If a set and a clear fall on the same cycle, the set wins.
- R7: `irq` is high exactly when the flag and the interrupt-enable bit (control bit 3) are both 1.
- R8: With the halt bit (control bit 8) set, enabled cycles leave the count unchanged. A control write with bits 8 and 7 both 1 lowers the count by one.
- R9: A single-step has no effect when the count is 1 (it never steps to 0) or when the count is 0 (it never steps to the modulus).
- R10: A control write with bit 6 = 1 copies the modulus into the counter. Bits 6 and 7 always read back as 0. Precedence is: count write, then copy, then modulus overwrite, then single-step, then counting.
- R11: With the debug bit (control bit 5) set, counting freezes while `dbg_halt` is high. With the debug bit clear, `dbg_halt` has no effect.
- R12: Writing 0 directly to the counter does not set the flag.
- R13: The control word is: bit 8 halt, 7 step, 6 copy, 5 debug, 4 overwrite, 3 interrupt enable, 2 flag, 1 reload. Bit 0 and bits above 8 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled count enable |
| dbg_halt | input | 1 | External debug request |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select (0 modulus, 1 count, 2 control/status) |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag set and a software clear landing on the same edge. The stimulus lets the counter run down to 1 by ticking, then raises `tick_en` in the very cycle that carries the clearing control write, and reads the flag back afterwards. The single-step guards need the counter parked at exactly 1 or 0 while halted. Direct writes to the count address put it there before each step is issued.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    // Control/status bit positions; software decodes these.
    localparam int BIT_RLD  = 1;
    localparam int BIT_IF   = 2;
    localparam int BIT_IE   = 3;
    localparam int BIT_OVW  = 4;
    localparam int BIT_DBG  = 5;
    localparam int BIT_LOAD = 6;
    localparam int BIT_STEP = 7;
    localparam int BIT_STOP = 8;
    localparam int CSR_W    = 9;

    typedef enum logic [1:0] {
        ADDR_MOD = 2'd0,
        ADDR_CNT = 2'd1,
        ADDR_CSR = 2'd2,
        ADDR_RSV = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic stop;
        logic dbg;
        logic ovw;
        logic ie;
        logic iflag;
        logic rld;
    } csr_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_WRITE,
        OP_LOAD,
        OP_OVW,
        OP_STEP,
        OP_TICK
    } cnt_op_e;

    function automatic logic [CSR_W-1:0] pack_csr(input csr_t c);
        logic [CSR_W-1:0] v;
        v           = '0;
        v[BIT_STOP] = c.stop;
        v[BIT_DBG]  = c.dbg;
        v[BIT_OVW]  = c.ovw;
        v[BIT_IE]   = c.ie;
        v[BIT_IF]   = c.iflag;
        v[BIT_RLD]  = c.rld;
        return v;
    endfunction

    function automatic logic step_allowed(input logic at_zero, input logic at_one);
        return !at_zero && !at_one;
    endfunction

endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
    import itmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 csr_wr,
    input  logic [CSR_W-1:1]     wr_bits,
    input  logic                 flag_set,
    output csr_t                 csr_q,
    output logic                 step_req,
    output logic                 load_req,
    output logic [CSR_W-1:0]     csr_rd
);

    csr_t csr_d;
    logic flag_clr;

    assign step_req = csr_wr && wr_bits[BIT_STEP] && wr_bits[BIT_STOP];
    assign load_req = csr_wr && wr_bits[BIT_LOAD];
    assign flag_clr = csr_wr && wr_bits[BIT_IF];

    always_comb begin
        csr_d = csr_q;
        if (csr_wr) begin
            csr_d.stop = wr_bits[BIT_STOP];
            csr_d.dbg  = wr_bits[BIT_DBG];
            csr_d.ovw  = wr_bits[BIT_OVW];
            csr_d.ie   = wr_bits[BIT_IE];
            csr_d.rld  = wr_bits[BIT_RLD];
        end
        csr_d.iflag = flag_set || (csr_q.iflag && !flag_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) csr_q <= '0;
        else     csr_q <= csr_d;
    end

    assign csr_rd = pack_csr(csr_q);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (csr_q.iflag && !flag_clr) |=> csr_q.iflag); // R6
    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> csr_q.iflag); // R6

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
    import itmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             dbg_halt,
    input  logic             stop,
    input  logic             dbg,
    input  logic             ovw,
    input  logic             rld,
    input  logic             cnt_wr,
    input  logic             mod_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step_req,
    input  logic             load_req,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] mod_q,
    output logic             zero_hit
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cnt_op_e          op;
    logic             running;
    logic             at_zero;
    logic             at_one;
    logic [CNT_W-1:0] cnt_d;
    logic             sw_touch;

    assign at_zero  = (cnt_q == '0);
    assign at_one   = (cnt_q == CNT_ONE);
    assign running  = tick_en && !stop && !(dbg && dbg_halt);
    assign sw_touch = cnt_wr || mod_wr || step_req || load_req;

    always_comb begin
        if (cnt_wr)               op = OP_WRITE;
        else if (load_req)        op = OP_LOAD;
        else if (mod_wr && ovw)   op = OP_OVW;
        else if (step_req)        op = OP_STEP;
        else if (running)         op = OP_TICK;
        else                      op = OP_HOLD;
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (op)
            OP_WRITE: cnt_d = wdata;
            OP_LOAD:  cnt_d = mod_q;
            OP_OVW:   cnt_d = wdata;
            OP_STEP:  if (step_allowed(at_zero, at_one)) cnt_d = cnt_q - CNT_ONE;
            OP_TICK:  begin
                if (at_zero) cnt_d = rld ? mod_q : CNT_MAX;
                else         cnt_d = cnt_q - CNT_ONE;
            end
            default:  cnt_d = cnt_q;
        endcase
    end

    assign zero_hit = (op == OP_TICK) && at_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mod_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (mod_wr) mod_q <= wdata;
        end
    end

    AST_STEP_GUARD: assert property (@(posedge clk) disable iff (rst)
        (step_req && !load_req && !cnt_wr && (cnt_q <= CNT_ONE)) |=> $stable(cnt_q)); // R9
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stop && !sw_touch) |=> $stable(cnt_q)); // R8
    AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (dbg && dbg_halt && !sw_touch) |=> $stable(cnt_q)); // R11
    AST_RELOAD_MOD: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !stop && !(dbg && dbg_halt) && (cnt_q == '0) && rld && !sw_touch)
        |=> (cnt_q == $past(mod_q))); // R2
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !stop && !(dbg && dbg_halt) && (cnt_q == '0) && !rld && !sw_touch)
        |=> (cnt_q == CNT_MAX)); // R3

endmodule

// File: rtl/itmr_top.sv
module itmr_top
    import itmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             dbg_halt,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);

    localparam int PAD_W = CNT_W - CSR_W;

    reg_addr_e        sel;
    logic             mod_wr;
    logic             cnt_wr;
    logic             csr_wr;
    csr_t             csr_q;
    logic             step_req;
    logic             load_req;
    logic [CSR_W-1:0] csr_rd;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_q;
    logic             zero_hit;

    assign sel    = reg_addr_e'(bus_addr);
    assign mod_wr = bus_wr && (sel == ADDR_MOD);
    assign cnt_wr = bus_wr && (sel == ADDR_CNT);
    assign csr_wr = bus_wr && (sel == ADDR_CSR);

    itmr_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .csr_wr   (csr_wr),
        .wr_bits  (bus_wdata[CSR_W-1:1]),
        .flag_set (zero_hit),
        .csr_q    (csr_q),
        .step_req (step_req),
        .load_req (load_req),
        .csr_rd   (csr_rd)
    );

    itmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .dbg_halt (dbg_halt),
        .stop     (csr_q.stop),
        .dbg      (csr_q.dbg),
        .ovw      (csr_q.ovw),
        .rld      (csr_q.rld),
        .cnt_wr   (cnt_wr),
        .mod_wr   (mod_wr),
        .wdata    (bus_wdata),
        .step_req (step_req),
        .load_req (load_req),
        .cnt_q    (cnt_q),
        .mod_q    (mod_q),
        .zero_hit (zero_hit)
    );

    always_comb begin
        unique case (sel)
            ADDR_MOD: bus_rdata = mod_q;
            ADDR_CNT: bus_rdata = cnt_q;
            ADDR_CSR: bus_rdata = {{PAD_W{1'b0}}, csr_rd};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = csr_q.iflag && csr_q.ie;

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        irq |-> csr_q.ie); // R7
    AST_DIRECT_WR_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !csr_q.iflag) |=> !csr_q.iflag); // R12

endmodule

// File: tb/itmr_top_tb_top.sv
module itmr_top_tb_top;

    localparam int CNT_W = 16;
    localparam logic [CNT_W-1:0] C_STOP = 16'h0100;
    localparam logic [CNT_W-1:0] C_STEP = 16'h0080;
    localparam logic [CNT_W-1:0] C_LOAD = 16'h0040;
    localparam logic [CNT_W-1:0] C_DBG  = 16'h0020;
    localparam logic [CNT_W-1:0] C_OVW  = 16'h0010;
    localparam logic [CNT_W-1:0] C_IE   = 16'h0008;
    localparam logic [CNT_W-1:0] C_IF   = 16'h0004;
    localparam logic [CNT_W-1:0] C_RLD  = 16'h0002;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick_en = 1'b0;
    logic             dbg_halt = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;
    logic             irq;

    typedef struct {
        bit               is_irq;
        logic [CNT_W-1:0] exp;
        string            req;
    } item_t;

    item_t sb_q[$];
    logic  chk_req = 1'b0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always #2 clk = ~clk;

    itmr_top #(.CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .dbg_halt  (dbg_halt),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Monitor: pops expected items and compares on the falling edge.
    always @(negedge clk) begin
        if (chk_req && sb_q.size() > 0) begin
            item_t it;
            logic [CNT_W-1:0] got;
            it  = sb_q.pop_front();
            got = it.is_irq ? {{(CNT_W-1){1'b0}}, irq} : bus_rdata;
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
            end
        end
    end

    // Driver tasks: entered and left one time unit after a rising edge.
    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic chk_reg(input logic [1:0] a, input logic [CNT_W-1:0] e, input string r);
        item_t it;
        it.is_irq = 1'b0; it.exp = e; it.req = r;
        bus_addr = a;
        sb_q.push_back(it);
        chk_req = 1'b1;
        @(posedge clk); #1;
        chk_req = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string r);
        item_t it;
        it.is_irq = 1'b1; it.exp = {{(CNT_W-1){1'b0}}, e}; it.req = r;
        sb_q.push_back(it);
        chk_req = 1'b1;
        @(posedge clk); #1;
        chk_req = 1'b0;
    endtask

    task automatic tick(input int n);
        tick_en = 1'b1;
        repeat (n) begin @(posedge clk); #1; end
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        chk_reg(2'd0, 16'h0000, "R1 modulus");
        chk_reg(2'd1, 16'h0000, "R1 count");
        chk_reg(2'd2, 16'h0000, "R1 control");
        chk_irq(1'b0, "R1 irq");

        wr(2'd0, 16'd5);
        chk_reg(2'd0, 16'd5, "R4 modulus readback");
        chk_reg(2'd1, 16'd0, "R5 no overwrite");
        wr(2'd2, C_RLD | C_IE);
        chk_reg(2'd2, C_RLD | C_IE, "R13 control readback");

        tick(1);
        chk_reg(2'd1, 16'd5, "R2 reload from zero");
        chk_reg(2'd2, C_RLD | C_IE, "R2 reload sets no flag");
        tick(4);
        chk_reg(2'd1, 16'd1, "R3 decrement");
        chk_irq(1'b0, "R7 irq low before event");
        tick(1);
        chk_reg(2'd1, 16'd0, "R3 reach zero");
        chk_reg(2'd2, C_RLD | C_IE | C_IF, "R6 flag set");
        chk_irq(1'b1, "R7 irq high");
        tick(1);
        chk_reg(2'd2, C_RLD | C_IE | C_IF, "R6 flag sticky");
        wr(2'd2, C_RLD | C_IE | C_IF);
        chk_reg(2'd2, C_RLD | C_IE, "R6 w1c clear");
        chk_irq(1'b0, "R7 irq low after clear");

        // set and clear on the same edge
        tick(4);
        tick_en = 1'b1;
        wr(2'd2, C_RLD | C_IE | C_IF);
        tick_en = 1'b0;
        chk_reg(2'd1, 16'd0, "R6 count at zero");
        chk_reg(2'd2, C_RLD | C_IE | C_IF, "R6 set wins over clear");
        wr(2'd2, C_RLD | C_IE | C_IF);

        // flag without enable
        wr(2'd2, C_RLD);
        tick(1);
        tick(5);
        chk_reg(2'd2, C_RLD | C_IF, "R6 flag with IE off");
        chk_irq(1'b0, "R7 irq masked");
        wr(2'd2, C_RLD | C_IE);
        chk_irq(1'b1, "R7 irq when enabled late");
        wr(2'd2, C_RLD | C_IE | C_IF);
        chk_irq(1'b0, "R7 irq cleared");

        // free running
        wr(2'd2, 16'h0000);
        tick(1);
        chk_reg(2'd1, 16'hFFFF, "R3 wrap to all ones");
        tick(2);
        chk_reg(2'd1, 16'hFFFD, "R3 free decrement");
        chk_reg(2'd1, 16'hFFFD, "R3 idle without tick");

        // direct count writes
        wr(2'd1, 16'd3);
        chk_reg(2'd1, 16'd3, "R4 direct count write");
        wr(2'd1, 16'd0);
        chk_reg(2'd1, 16'd0, "R12 direct zero");
        chk_reg(2'd2, 16'h0000, "R12 no flag on direct zero");

        // overwrite
        wr(2'd2, C_OVW);
        wr(2'd0, 16'd9);
        chk_reg(2'd0, 16'd9, "R5 modulus with overwrite");
        chk_reg(2'd1, 16'd9, "R5 count loaded at once");
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'd7);
        chk_reg(2'd0, 16'd7, "R5 modulus without overwrite");
        chk_reg(2'd1, 16'd9, "R5 count untouched");

        // halt and step
        wr(2'd2, C_STOP);
        tick(3);
        chk_reg(2'd1, 16'd9, "R8 halted");
        wr(2'd2, C_STOP | C_STEP);
        chk_reg(2'd1, 16'd8, "R8 single step");
        chk_reg(2'd2, C_STOP, "R10 step reads zero");
        wr(2'd1, 16'd1);
        wr(2'd2, C_STOP | C_STEP);
        chk_reg(2'd1, 16'd1, "R9 no step 1 to 0");
        wr(2'd1, 16'd0);
        wr(2'd2, C_STOP | C_STEP);
        chk_reg(2'd1, 16'd0, "R9 no step 0 to modulus");
        chk_reg(2'd2, C_STOP, "R9 no flag from step");

        // copy modulus
        wr(2'd2, C_STOP | C_LOAD);
        chk_reg(2'd1, 16'd7, "R10 copy modulus");
        chk_reg(2'd2, C_STOP, "R10 copy bit reads zero");

        // debug freeze
        wr(2'd2, C_DBG);
        dbg_halt = 1'b1;
        tick(3);
        chk_reg(2'd1, 16'd7, "R11 frozen in debug");
        dbg_halt = 1'b0;
        tick(2);
        chk_reg(2'd1, 16'd5, "R11 resumes");
        wr(2'd2, 16'h0000);
        dbg_halt = 1'b1;
        tick(1);
        dbg_halt = 1'b0;
        chk_reg(2'd1, 16'd4, "R11 debug input ignored");

        // full control write
        wr(2'd2, 16'hFFFF);
        chk_reg(2'd2, C_STOP | C_DBG | C_OVW | C_IE | C_RLD, "R13 bit layout");
        chk_reg(2'd1, 16'd7, "R10 copy beats step");
        chk_reg(2'd3, 16'h0000, "R13 spare address");
        chk_irq(1'b0, "R7 irq with flag clear");

        repeat (2) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule